// File: doc/BRIEF.md
# Multi-Page-Size Data TLB

This block translates data virtual addresses to physical addresses with a fully associative array of translations. Every entry records its own page size (8 KB, 64 KB, 4 MB or 256 MB), so entries of different sizes sit side by side. Each entry also holds a context tag, a physical page number and a small attribute field whose bit 0 means writable. One lookup may be presented per cycle. The result comes back exactly one cycle later: hit, physical address, attributes, a store-to-read-only fault flag and a multiple-match flag.

A lookup that misses raises a request, in the same cycle as its response, to an external hardware page table walker. The request carries the missing virtual address and context. The walker later answers through the fill port, and the block chooses the entry to overwrite. Software or the walker can also clear the whole array, or clear every entry of one context, in a single cycle.

Top module: `dtlb_mps`

## Requirements
- R1: After reset every entry is invalid, so the first lookup misses.
- R2: A lookup presented with `lk_valid` in cycle N produces `rsp_valid` in cycle N+1, and only then, with hit, address and attributes for that lookup.
- R3: `fill_size` codes are 0 = 8 KB, 1 = 64 KB, 2 = 4 MB and 3 = 256 MB, with page offsets of 13, 16, 22 and 28 bits. A lookup hits an entry only when the contexts are equal and all virtual-address bits at and above that entry's offset are equal. Bits below the offset are ignored.
- R4: On a hit, the physical address takes its bits below the entry's page offset from the lookup address and its upper bits from the entry's physical address.
- R5: A miss asserts `walk_req` in the response cycle, with `walk_va` and `walk_ctx` equal to the lookup's address and context. A hit never asserts it.
- R6: A fill writes the lowest-numbered invalid entry, judged on the state before that cycle.
- R7: When no entry is invalid, a fill overwrites the entry named by a round-robin pointer. The pointer starts at 0 after reset, moves up by one on every accepted fill and wraps, and is not cleared by invalidation.
- R8: When several valid entries match, `rsp_multi` is set and the lowest-index match supplies the address and attributes.
- R9: `inv_ctx_valid` clears, in one cycle, every entry whose context equals `inv_ctx` and leaves the others.
- R10: `inv_all` clears every entry, and a fill in the same cycle is dropped.
- R11: A store lookup (`lk_store` = 1) that hits an entry whose attribute bit 0 is 0 sets `rsp_wfault`. Loads and writable entries never set it.
- R12: A lookup sees the array as it was before that cycle's fill and invalidations. When a fill and a context invalidate share a cycle, the new entry survives even if its context matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_va | input | VA_W | Lookup virtual address |
| lk_ctx | input | CTX_W | Lookup context tag |
| lk_store | input | 1 | Lookup is a store |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_wfault | output | 1 | Store hit a non-writable entry |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_attr | output | ATTR_W | Attributes of the selected entry |
| walk_req | output | 1 | Miss request to the page table walker |
| walk_va | output | VA_W | Virtual address to walk |
| walk_ctx | output | CTX_W | Context to walk |
| fill_valid | input | 1 | Walker response present |
| fill_va | input | VA_W | Virtual address of the new translation |
| fill_ctx | input | CTX_W | Context of the new translation |
| fill_pa | input | PA_W | Physical address of the new translation |
| fill_size | input | 2 | Page-size code of the new translation |
| fill_attr | input | ATTR_W | Attributes of the new translation |
| inv_all | input | 1 | Clear every entry |
| inv_ctx_valid | input | 1 | Clear entries of one context |
| inv_ctx | input | CTX_W | Context to clear |

## Verification
Directed lookups flip one address bit just above and just below each page size's offset. This shows whether the per-entry compare mask and the address splice follow the entry's size code and not a fixed one. Lookups with a changed context separate context matching from address matching. Duplicate fills, and fills that share a cycle with a lookup or an invalidate, expose the priority and ordering rules. Filling the whole array and then one more entry shows the free-slot search handing over to the round-robin pointer. Constrained random traffic then mixes lookups near existing pages, random misses, fills of all four sizes and both kinds of invalidation, and compares each response with a bench model.

// File: rtl/tlb_mps_pkg.sv
package tlb_mps_pkg;
   localparam int unsigned BASE_SHIFT = 13;
   localparam int unsigned MAX_SHIFT  = 28;

   typedef enum logic [1:0] {
      PG_8K   = 2'b00,
      PG_64K  = 2'b01,
      PG_4M   = 2'b10,
      PG_256M = 2'b11
   } pg_size_e;

   function automatic int unsigned pg_shift(input pg_size_e s);
      case (s)
         PG_8K:   return 13;
         PG_64K:  return 16;
         PG_4M:   return 22;
         default: return 28;
      endcase
   endfunction
endpackage

// File: rtl/tlb_mps_cam.sv
module tlb_mps_cam
   import tlb_mps_pkg::*;
#(
   parameter int ENTRIES = 128,
   parameter int VPN_W   = 35,
   parameter int CTX_W   = 13
) (
   input  logic [ENTRIES-1:0] ent_vld,
   input  logic [VPN_W-1:0]   ent_vpn [ENTRIES],
   input  logic [CTX_W-1:0]   ent_ctx [ENTRIES],
   input  pg_size_e           ent_sz  [ENTRIES],
   input  logic [VPN_W-1:0]   q_vpn,
   input  logic [CTX_W-1:0]   q_ctx,
   output logic [ENTRIES-1:0] match
);
   // one comparator per entry, masked by that entry's own page size
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [VPN_W-1:0] keep;
      assign keep = ~((VPN_W'(1) << (pg_shift(ent_sz[g]) - BASE_SHIFT)) - VPN_W'(1));
      assign match[g] = ent_vld[g] && (ent_ctx[g] == q_ctx)
                        && (((ent_vpn[g] ^ q_vpn) & keep) == '0);
   end
endmodule

// File: rtl/tlb_mps_pick.sv
module tlb_mps_pick #(
   parameter  int N  = 128,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/tlb_mps_victim.sv
module tlb_mps_victim #(
   parameter  int ENTRIES = 128,
   localparam int IW      = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] ent_vld,
   input  logic               fill_fire,
   output logic [IW-1:0]      victim
);
   logic          free_any;
   logic [IW-1:0] free_idx;
   logic [IW-1:0] rr_q;

   tlb_mps_pick #(.N(ENTRIES)) u_free (
      .req (~ent_vld),
      .any (free_any),
      .idx (free_idx)
   );

   // the pointer moves on every accepted fill, whether it was used or not
   always_ff @(posedge clk) begin
      if (!rst_n)         rr_q <= '0;
      else if (fill_fire) rr_q <= rr_q + IW'(1);
   end

   assign victim = free_any ? free_idx : rr_q;
endmodule

// File: rtl/dtlb_mps.sv
module dtlb_mps
   import tlb_mps_pkg::*;
#(
   parameter int ENTRIES = 128,
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int CTX_W   = 13,
   parameter int ATTR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [CTX_W-1:0]  lk_ctx,
   input  logic              lk_store,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_multi,
   output logic              rsp_wfault,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic              walk_req,
   output logic [VA_W-1:0]   walk_va,
   output logic [CTX_W-1:0]  walk_ctx,
   input  logic              fill_valid,
   input  logic [VA_W-1:0]   fill_va,
   input  logic [CTX_W-1:0]  fill_ctx,
   input  logic [PA_W-1:0]   fill_pa,
   input  logic [1:0]        fill_size,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              inv_all,
   input  logic              inv_ctx_valid,
   input  logic [CTX_W-1:0]  inv_ctx
);
   localparam int IW    = $clog2(ENTRIES);
   localparam int VPN_W = VA_W - BASE_SHIFT;
   localparam int PPN_W = PA_W - BASE_SHIFT;

   // elaboration-time parameter checks
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (VA_W <= MAX_SHIFT || PA_W <= MAX_SHIFT) begin : g_bad_width
      $error("address widths must exceed the largest page offset");
   end
   if (ATTR_W < 1 || CTX_W < 1) begin : g_bad_field
      $error("attribute and context widths must be positive");
   end

   // entry storage
   logic [ENTRIES-1:0] vld_q, vld_d;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [CTX_W-1:0]   ctx_q  [ENTRIES];
   pg_size_e           sz_q   [ENTRIES];
   logic [ATTR_W-1:0]  attr_q [ENTRIES];

   // lookup side
   logic [ENTRIES-1:0] hit_vec;
   logic               hit_any;
   logic [IW-1:0]      hit_idx;
   logic               hit_many;
   logic [PA_W-1:0]    lo_mask;
   logic [PA_W-1:0]    pa_sel;
   logic [ATTR_W-1:0]  attr_sel;

   tlb_mps_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_cam (
      .ent_vld (vld_q),
      .ent_vpn (vpn_q),
      .ent_ctx (ctx_q),
      .ent_sz  (sz_q),
      .q_vpn   (lk_va[VA_W-1:BASE_SHIFT]),
      .q_ctx   (lk_ctx),
      .match   (hit_vec)
   );

   tlb_mps_pick #(.N(ENTRIES)) u_hit (
      .req (hit_vec),
      .any (hit_any),
      .idx (hit_idx)
   );

   assign hit_many = |(hit_vec & (hit_vec - ENTRIES'(1)));
   assign lo_mask  = (PA_W'(1) << pg_shift(sz_q[hit_idx])) - PA_W'(1);
   assign pa_sel   = ({ppn_q[hit_idx], {BASE_SHIFT{1'b0}}} & ~lo_mask)
                   | (PA_W'(lk_va[MAX_SHIFT-1:0]) & lo_mask);
   assign attr_sel = attr_q[hit_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_multi  <= 1'b0;
         rsp_wfault <= 1'b0;
         rsp_pa     <= '0;
         rsp_attr   <= '0;
         walk_req   <= 1'b0;
         walk_va    <= '0;
         walk_ctx   <= '0;
      end else begin
         rsp_valid  <= lk_valid;
         rsp_hit    <= lk_valid && hit_any;
         rsp_multi  <= lk_valid && hit_any && hit_many;
         rsp_wfault <= lk_valid && hit_any && lk_store && !attr_sel[0];
         walk_req   <= lk_valid && !hit_any;
         if (lk_valid) begin
            rsp_pa   <= hit_any ? pa_sel : '0;
            rsp_attr <= hit_any ? attr_sel : '0;
            walk_va  <= lk_va;
            walk_ctx <= lk_ctx;
         end
      end
   end

   // update side
   logic               fill_fire;
   logic [IW-1:0]      victim;
   logic [ENTRIES-1:0] ctx_kill;

   assign fill_fire = fill_valid && !inv_all;

   tlb_mps_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_vld   (vld_q),
      .fill_fire (fill_fire),
      .victim    (victim)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
      assign ctx_kill[g] = inv_ctx_valid && (ctx_q[g] == inv_ctx);
   end

   // invalidation first, then the fill on top of it
   always_comb begin
      vld_d = vld_q & ~ctx_kill;
      if (fill_fire) vld_d[victim] = 1'b1;
      if (inv_all)   vld_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
   end

   always_ff @(posedge clk) begin
      if (fill_fire) begin
         vpn_q[victim]  <= fill_va[VA_W-1:BASE_SHIFT];
         ppn_q[victim]  <= fill_pa[PA_W-1:BASE_SHIFT];
         ctx_q[victim]  <= fill_ctx;
         sz_q[victim]   <= pg_size_e'(fill_size);
         attr_q[victim] <= fill_attr;
      end
   end
endmodule

// File: rtl/dtlb_mps_chk.sv
module dtlb_mps_chk #(
   parameter int ENTRIES = 128,
   parameter int VA_W    = 48
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VA_W-1:0]    lk_va,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_multi,
   input logic               rsp_wfault,
   input logic               walk_req,
   input logic [VA_W-1:0]    walk_va,
   input logic               fill_valid,
   input logic               inv_all,
   input logic               inv_ctx_valid,
   input logic [ENTRIES-1:0] vld_q
);
   a_r1_empty_after_reset: assert property (@(posedge clk)
      !rst_n |=> vld_q == '0);

   a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   a_r2_no_rsp_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   a_r5_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> walk_req);

   a_r5_no_walk_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> (rsp_valid && !rsp_hit));

   a_r5_walk_addr: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> walk_va == $past(lk_va));

   a_r6_fill_takes_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !inv_all && !inv_ctx_valid && !(&vld_q))
      |=> $countones(vld_q) == $past($countones(vld_q)) + 1);

   a_r8_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi |-> rsp_hit);

   a_r10_inv_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> vld_q == '0);

   a_r11_fault_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wfault |-> rsp_hit);
endmodule

bind dtlb_mps dtlb_mps_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_va         (lk_va),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_multi     (rsp_multi),
   .rsp_wfault    (rsp_wfault),
   .walk_req      (walk_req),
   .walk_va       (walk_va),
   .fill_valid    (fill_valid),
   .inv_all       (inv_all),
   .inv_ctx_valid (inv_ctx_valid),
   .vld_q         (vld_q)
);

// File: tb/tb_dtlb_mps.sv
module tb_dtlb_mps;
   localparam int E      = 128;
   localparam int VA_W   = 48;
   localparam int PA_W   = 40;
   localparam int CTX_W  = 13;
   localparam int ATTR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0, lk_store = 1'b0;
   logic [VA_W-1:0]   lk_va = '0;
   logic [CTX_W-1:0]  lk_ctx = '0;
   logic              rsp_valid, rsp_hit, rsp_multi, rsp_wfault, walk_req;
   logic [PA_W-1:0]   rsp_pa;
   logic [ATTR_W-1:0] rsp_attr;
   logic [VA_W-1:0]   walk_va;
   logic [CTX_W-1:0]  walk_ctx;
   logic              fill_valid = 1'b0;
   logic [VA_W-1:0]   fill_va = '0;
   logic [CTX_W-1:0]  fill_ctx = '0;
   logic [PA_W-1:0]   fill_pa = '0;
   logic [1:0]        fill_size = '0;
   logic [ATTR_W-1:0] fill_attr = '0;
   logic              inv_all = 1'b0, inv_ctx_valid = 1'b0;
   logic [CTX_W-1:0]  inv_ctx = '0;

   always #5 clk = ~clk;

   dtlb_mps dut (.*);

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model of the array
   bit                m_vld  [E];
   logic [VA_W-1:0]   m_va   [E];
   logic [CTX_W-1:0]  m_ctx  [E];
   logic [PA_W-1:0]   m_pa   [E];
   logic [1:0]        m_sz   [E];
   logic [ATTR_W-1:0] m_attr [E];
   int                m_rr = 0;

   function automatic int shift_of(input logic [1:0] s);
      case (s)
         2'd0: return 13;
         2'd1: return 16;
         2'd2: return 22;
         default: return 28;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock cycle with any mix of operations; the model follows the requirements
   task automatic cycle(input bit lk, input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                        input bit st, input bit f, input logic [VA_W-1:0] fva,
                        input logic [CTX_W-1:0] fctx, input logic [PA_W-1:0] fpa,
                        input logic [1:0] fsz, input logic [ATTR_W-1:0] fattr,
                        input bit ia, input bit ic, input logic [CTX_W-1:0] icv,
                        input string req);
      bit e_hit = 0, e_multi = 0, e_wf;
      logic [PA_W-1:0] e_pa = '0;
      logic [ATTR_W-1:0] e_attr = '0;
      int vic = -1;
      // expected response from the state before this cycle (R12)
      for (int i = 0; i < E; i++) begin
         if (m_vld[i] && m_ctx[i] == ctx && ((m_va[i] ^ va) >> shift_of(m_sz[i])) == 0) begin
            if (!e_hit) begin
               int sh = shift_of(m_sz[i]);
               e_hit  = 1;
               e_pa   = ((m_pa[i] >> sh) << sh) | (PA_W'(va) & ((PA_W'(1) << sh) - 1));
               e_attr = m_attr[i];
            end else e_multi = 1;
         end
      end
      e_wf = e_hit && st && !e_attr[0];
      for (int i = E - 1; i >= 0; i--) if (!m_vld[i]) vic = i;
      if (vic < 0) vic = m_rr;
      @(negedge clk);
      lk_valid = lk; lk_va = va; lk_ctx = ctx; lk_store = st;
      fill_valid = f; fill_va = fva; fill_ctx = fctx; fill_pa = fpa;
      fill_size = fsz; fill_attr = fattr;
      inv_all = ia; inv_ctx_valid = ic; inv_ctx = icv;
      @(posedge clk);
      #1;
      lk_valid = 0; fill_valid = 0; inv_all = 0; inv_ctx_valid = 0;
      if (lk) begin
         chk({rsp_valid, rsp_hit, rsp_multi, rsp_wfault, walk_req} ==
             {1'b1, e_hit, e_multi, e_wf, !e_hit}, req, "flags v/hit/multi/wf/walk",
             64'({rsp_valid, rsp_hit, rsp_multi, rsp_wfault, walk_req}),
             64'({1'b1, e_hit, e_multi, e_wf, !e_hit}));
         if (e_hit)
            chk(rsp_pa == e_pa && rsp_attr == e_attr, req, "pa/attr",
                64'({rsp_attr, rsp_pa}), 64'({e_attr, e_pa}));
         else
            chk(walk_va == va && walk_ctx == ctx, req, "walk va/ctx",
                64'({walk_ctx, walk_va}), 64'({ctx, va}));
      end else begin
         chk(!rsp_valid, req, "idle rsp_valid", 64'(rsp_valid), 64'(0));
      end
      // model update: invalidate, then fill on the pre-cycle victim
      if (ia) begin
         for (int i = 0; i < E; i++) m_vld[i] = 0;
      end else begin
         if (ic) for (int i = 0; i < E; i++) if (m_ctx[i] == icv) m_vld[i] = 0;
         if (f) begin
            m_vld[vic] = 1; m_va[vic] = fva; m_ctx[vic] = fctx; m_pa[vic] = fpa;
            m_sz[vic] = fsz; m_attr[vic] = fattr;
            m_rr = (m_rr + 1) % E;
         end
      end
   endtask

   task automatic look(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                       input bit st, input string req);
      cycle(1, va, ctx, st, 0, '0, '0, '0, 0, '0, 0, 0, '0, req);
   endtask

   task automatic fill(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                       input logic [PA_W-1:0] pa, input logic [1:0] sz,
                       input logic [ATTR_W-1:0] at, input string req);
      cycle(0, '0, '0, 0, 1, va, ctx, pa, sz, at, 0, 0, '0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [VA_W-1:0] a;
      void'($urandom(32'd2024));
      for (int i = 0; i < E; i++) m_vld[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 R5: empty array, miss raises walk request
      look(48'h1234_5678_9000, 13'd1, 0, "R1");
      look(48'h0000_0000_2000, 13'd0, 0, "R5");

      // R2 R3 R4: 8 KB page
      a = 48'h0A00_0000_6000;
      fill(a, 13'd1, 40'h12_3456_6000, 2'd0, 4'h1, "R6");
      look(a | 48'h1ABC, 13'd1, 0, "R2");
      look(a | 48'h2000, 13'd1, 0, "R3");
      look(a | 48'h0FFF, 13'd2, 0, "R3");
      // 64 KB, 4 MB and 256 MB pages: bits below the offset ignored, splice from VA
      fill(48'h0B00_0001_0000, 13'd1, 40'h33_0000_0000, 2'd1, 4'h3, "R3");
      look(48'h0B00_0001_E123, 13'd1, 0, "R4");
      look(48'h0B00_0002_0000, 13'd1, 0, "R3");
      fill(48'h0C00_0040_0000, 13'd1, 40'h44_1FC0_0000, 2'd2, 4'h5, "R3");
      look(48'h0C00_007F_FFFF, 13'd1, 0, "R4");
      fill(48'h0D00_1000_0000, 13'd1, 40'h55_7000_0000, 2'd3, 4'h0, "R3");
      look(48'h0D00_1ABC_DEF0, 13'd1, 0, "R4");
      look(48'h0D00_2000_0000, 13'd1, 0, "R3");
      // R11: store to read-only and writable entries, load to read-only
      look(48'h0D00_1000_0040, 13'd1, 1, "R11");
      look(48'h0D00_1000_0040, 13'd1, 0, "R11");
      look(a, 13'd1, 1, "R11");
      // R8: duplicate translations, lowest index wins
      fill(48'h0E00_0000_2000, 13'd3, 40'h01_0000_2000, 2'd0, 4'h1, "R8");
      fill(48'h0E00_0000_2000, 13'd3, 40'h02_0000_2000, 2'd0, 4'h7, "R8");
      look(48'h0E00_0000_2468, 13'd3, 0, "R8");
      // R12: lookup in the same cycle as its fill misses, then hits
      cycle(1, 48'h0F00_0000_4000, 13'd4, 0, 1, 48'h0F00_0000_4000, 13'd4,
            40'h0A_0000_4000, 2'd0, 4'h1, 0, 0, '0, "R12");
      look(48'h0F00_0000_4000, 13'd4, 0, "R12");
      // R9 R12: context invalidate with a same-context fill in the same cycle
      cycle(0, '0, '0, 0, 1, 48'h0F10_0000_0000, 13'd1, 40'h0B_0000_0000,
            2'd0, 4'h1, 0, 1, 13'd1, "R9");
      look(a, 13'd1, 0, "R9");
      look(48'h0F10_0000_0010, 13'd1, 0, "R12");
      look(48'h0E00_0000_2000, 13'd3, 0, "R9");
      // R10: clear all, same-cycle fill dropped
      cycle(0, '0, '0, 0, 1, 48'h0F20_0000_0000, 13'd2, 40'h0C_0000_0000,
            2'd0, 4'h1, 1, 0, '0, "R10");
      look(48'h0F20_0000_0000, 13'd2, 0, "R10");
      look(48'h0E00_0000_2000, 13'd3, 0, "R10");
      // R6 R7: fill every entry, then overflow onto the round-robin pointer
      for (int i = 0; i < E + 2; i++)
         fill(48'h1000_0000_0000 + (48'(i) << 13), 13'd5,
              40'h80_0000_0000 + (40'(i) << 13), 2'd0, 4'h1, "R7");
      for (int i = 0; i < 4; i++)
         look(48'h1000_0000_0000 + (48'(i) << 13), 13'd5, 0, "R7");
      look(48'h1000_0000_0000 + (48'(E + 1) << 13), 13'd5, 0, "R6");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int op = int'($urandom_range(99));
         int k  = int'($urandom_range(E - 1));
         logic [VA_W-1:0] rva = VA_W'({$urandom(), $urandom()});
         logic [CTX_W-1:0] rc = CTX_W'($urandom_range(3));
         if (op < 55) begin
            if (m_vld[k] && op < 40)
               look(m_va[k] ^ (rva & ((VA_W'(1) << shift_of(m_sz[k])) - 1)), m_ctx[k],
                    bit'($urandom_range(1)), "R3 random");
            else
               look(rva, rc, bit'($urandom_range(1)), "R5 random");
         end else if (op < 93) begin
            cycle(bit'($urandom_range(1)), m_va[k], m_ctx[k], 0, 1, rva, rc,
                  PA_W'({$urandom(), $urandom()}), 2'($urandom_range(3)),
                  ATTR_W'($urandom_range(15)), 0, 0, '0, "R6 random");
         end else if (op < 99) begin
            cycle(1, rva, rc, 0, 0, '0, '0, '0, 0, '0, 0, 1, rc, "R9 random");
         end else begin
            cycle(0, '0, '0, 0, 0, '0, '0, '0, 0, '0, 1, 0, '0, "R10 random");
         end
      end
      finish_run();
   end
endmodule